// File: doc/BRIEF.md
# GPIO Bank Pad-Control Register File

This block is the control register set for one bank of eight general-purpose pins. A simple strobe-based bus writes and reads four 32-bit registers. The first selects each pin's function, the second holds output data, the third sets pull resistors, and the fourth sets drive strength and slew rate. From these registers the block drives the per-pin pad controls continuously: output value, output enable, pull-up enable, pull-down enable, a 2-bit drive strength and a slew select. It also passes the raw function codes on to the alternate-function multiplexing that sits outside this block.

Pad input levels pass through a two-flop synchroniser before they can be read back. A read of the data register returns different sources per pin. A pin in output mode returns the value stored for it. Any other pin returns its synchronised input level. Reads are registered: `rdata` updates on the clock edge where `rd_en` is high and holds its value at every other edge. Writes take effect on the clock edge where `wr_en` is high, and the pad outputs follow combinationally from the stored values.

Top module: `gpio_padbank`

## Requirements
- R1: After reset, all four registers read zero. Every pin is then in input mode, so `pad_oe`, `pad_out`, `pad_pu` and `pad_pd` are all zero.
- R2: The function register (byte offset 0x0) holds a 4-bit code per pin at bits [4p+3:4p]. It reads back exactly as written, and `pad_func` presents it unchanged.
- R3: `pad_oe[p]` is 1 only when pin p's function code is 1, which is output mode. Code 0 is input mode, and codes 2 to 15 are alternate functions. `pad_out[p]` equals data bit p when `pad_oe[p]` is 1 and is 0 otherwise.
- R4: The pull register (offset 0x8) holds a 2-bit code per pin at bits [2p+1:2p]. Code 1 asserts `pad_pd[p]` and code 3 asserts `pad_pu[p]`. Codes 0 and 2 assert neither. The register reads back as written, with bits [31:16] reading zero.
- R5: The drive register (offset 0xC) holds a 2-bit strength code per pin at bits [2p+1:2p], with codes 0 to 3 meaning 1x to 4x. These bits appear on `pad_drv`. Pin p's slew select sits at bit 16+p and appears on `pad_slew[p]`. Bits [31:24] are not stored and read zero.
- R6: A read of the data register (offset 0x4) returns the stored data bit for each pin in output mode. For every other pin, including pins set to an alternate function, it returns the synchronised `pad_in` level.
- R7: A change on `pad_in` is first visible to a read strobed on the third rising edge after the change. A read strobed on the second rising edge still returns the old level.
- R8: Offsets at or above 0x10, and offsets that are not a multiple of four, read as zero. Writes to them change no register.
- R9: Data register bits [31:8] are not stored. Writing them has no effect on `pad_out`, and they read zero.
- R10: `rdata` keeps its value at every clock edge where `rd_en` is low, whatever `addr` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 8 | Pin input levels from the pads |
| pad_out | output | 8 | Per-pin output value |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin pull-up enable |
| pad_pd | output | 8 | Per-pin pull-down enable |
| pad_drv | output | 16 | Per-pin 2-bit drive strength |
| pad_slew | output | 8 | Per-pin slew select |
| pad_func | output | 32 | Per-pin 4-bit function code |

## Verification
The bench builds the block with its defaults: eight pins and a 6-bit byte address. With these values the sweeps can be exhaustive. Every one of the 16 function codes is tried on every pin, every pull and drive code and both slew values on every pin, all 256 output data patterns, and every one of the sixteen word offsets in the address space, including the twelve that are unmapped. Because the address is small, a misaligned offset can also be exercised, and the synchroniser latency can be pinned to the exact edge.

// File: rtl/gpio_padbank_pkg.sv
package gpio_padbank_pkg;

    localparam int unsigned CODE_W = 4;
    localparam int unsigned PULL_W = 2;
    localparam int unsigned DRV_W  = 2;

    localparam logic [CODE_W-1:0] FN_INPUT  = 4'd0;
    localparam logic [CODE_W-1:0] FN_OUTPUT = 4'd1;

    typedef enum logic [PULL_W-1:0] {
        PULL_NONE = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_RSVD = 2'd2,
        PULL_UP   = 2'd3
    } pull_code_e;

    typedef enum logic [2:0] {
        SEL_FUNC  = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_PULL  = 3'd2,
        SEL_DRIVE = 3'd3,
        SEL_NONE  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_padbank_sync.sv
module gpio_padbank_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stable_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= async_in[i];
                stable_q <= meta_q;
            end
        end

        assign sync_out[i] = stable_q;
    end

endmodule

// File: rtl/gpio_padbank_regs.sv
module gpio_padbank_regs
    import gpio_padbank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SLEW_LSB = 16,
    localparam int unsigned FUNC_BITS = NUM_PINS * CODE_W,
    localparam int unsigned PULL_BITS = NUM_PINS * PULL_W,
    localparam int unsigned DRV_BITS  = NUM_PINS * DRV_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  reg_sel_e             sel,
    input  logic [DATA_W-1:0]    wdata,
    output logic [FUNC_BITS-1:0] func_q,
    output logic [NUM_PINS-1:0]  data_q,
    output logic [PULL_BITS-1:0] pull_q,
    output logic [DRV_BITS-1:0]  drv_q,
    output logic [NUM_PINS-1:0]  slew_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= '0;
            data_q <= '0;
            pull_q <= '0;
            drv_q  <= '0;
            slew_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_FUNC:  func_q <= wdata[FUNC_BITS-1:0];
                SEL_DATA:  data_q <= wdata[NUM_PINS-1:0];
                SEL_PULL:  pull_q <= wdata[PULL_BITS-1:0];
                SEL_DRIVE: begin
                    drv_q  <= wdata[DRV_BITS-1:0];
                    slew_q <= wdata[SLEW_LSB +: NUM_PINS];
                end
                SEL_NONE:  ;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_padbank_decode.sv
module gpio_padbank_decode
    import gpio_padbank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    localparam int unsigned FUNC_BITS = NUM_PINS * CODE_W,
    localparam int unsigned PULL_BITS = NUM_PINS * PULL_W
) (
    input  logic [FUNC_BITS-1:0] func_q,
    input  logic [NUM_PINS-1:0]  data_q,
    input  logic [PULL_BITS-1:0] pull_q,
    output logic [NUM_PINS-1:0]  oe,
    output logic [NUM_PINS-1:0]  out,
    output logic [NUM_PINS-1:0]  pu,
    output logic [NUM_PINS-1:0]  pd
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [CODE_W-1:0] code;
        pull_code_e        pull;

        assign code = func_q[p*CODE_W +: CODE_W];
        assign pull = pull_code_e'(pull_q[p*PULL_W +: PULL_W]);

        always_comb begin
            oe[p]  = (code == FN_OUTPUT);
            out[p] = oe[p] & data_q[p];
            pu[p]  = 1'b0;
            pd[p]  = 1'b0;
            unique case (pull)
                PULL_UP:   pu[p] = 1'b1;
                PULL_DOWN: pd[p] = 1'b1;
                PULL_NONE: ;
                PULL_RSVD: ;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_padbank.sv
module gpio_padbank
    import gpio_padbank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SLEW_LSB = 16,
    localparam int unsigned FUNC_BITS = NUM_PINS * CODE_W,
    localparam int unsigned PULL_BITS = NUM_PINS * PULL_W,
    localparam int unsigned DRV_BITS  = NUM_PINS * DRV_W,
    localparam int unsigned WORD_W    = ADDR_W - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pad_out,
    output logic [NUM_PINS-1:0]  pad_oe,
    output logic [NUM_PINS-1:0]  pad_pu,
    output logic [NUM_PINS-1:0]  pad_pd,
    output logic [DRV_BITS-1:0]  pad_drv,
    output logic [NUM_PINS-1:0]  pad_slew,
    output logic [FUNC_BITS-1:0] pad_func
);

    logic [FUNC_BITS-1:0] func_q;
    logic [NUM_PINS-1:0]  data_q;
    logic [PULL_BITS-1:0] pull_q;
    logic [DRV_BITS-1:0]  drv_q;
    logic [NUM_PINS-1:0]  slew_q;
    logic [NUM_PINS-1:0]  in_sync;
    logic [NUM_PINS-1:0]  oe_w;
    logic [DATA_W-1:0]    rd_next;
    reg_sel_e             sel;

    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            unique case (addr[ADDR_W-1:2])
                WORD_W'(0): sel = SEL_FUNC;
                WORD_W'(1): sel = SEL_DATA;
                WORD_W'(2): sel = SEL_PULL;
                WORD_W'(3): sel = SEL_DRIVE;
                default:    sel = SEL_NONE;
            endcase
        end
    end

    gpio_padbank_regs #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .SLEW_LSB (SLEW_LSB)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (wdata),
        .func_q (func_q),
        .data_q (data_q),
        .pull_q (pull_q),
        .drv_q  (drv_q),
        .slew_q (slew_q)
    );

    gpio_padbank_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    gpio_padbank_decode #(
        .NUM_PINS (NUM_PINS)
    ) u_decode (
        .func_q (func_q),
        .data_q (data_q),
        .pull_q (pull_q),
        .oe     (oe_w),
        .out    (pad_out),
        .pu     (pad_pu),
        .pd     (pad_pd)
    );

    assign pad_oe   = oe_w;
    assign pad_drv  = drv_q;
    assign pad_slew = slew_q;
    assign pad_func = func_q;

    // Output-mode pins read back their stored bit, all others the synchronised level.
    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_FUNC:  rd_next[FUNC_BITS-1:0] = func_q;
            SEL_DATA:  rd_next[NUM_PINS-1:0]  = (data_q & oe_w) | (in_sync & ~oe_w);
            SEL_PULL:  rd_next[PULL_BITS-1:0] = pull_q;
            SEL_DRIVE: begin
                rd_next[DRV_BITS-1:0]          = drv_q;
                rd_next[SLEW_LSB +: NUM_PINS]  = slew_q;
            end
            SEL_NONE:  rd_next = '0;
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/gpio_padbank_chk.sv
module gpio_padbank_chk
    import gpio_padbank_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned FUNC_BITS = NUM_PINS * CODE_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_PINS-1:0]  pad_out,
    input logic [NUM_PINS-1:0]  pad_oe,
    input logic [NUM_PINS-1:0]  pad_pu,
    input logic [NUM_PINS-1:0]  pad_pd,
    input logic [FUNC_BITS-1:0] pad_func
);

    logic func_wr;
    logic unmapped;
    logic [NUM_PINS-1:0] oe_expect;

    assign func_wr  = wr_en && (addr == '0);
    assign unmapped = (addr[1:0] != 2'b00) || (addr[ADDR_W-1:2] > (ADDR_W-2)'(3));

    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            oe_expect[p] = (pad_func[p*CODE_W +: CODE_W] == FN_OUTPUT);
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && pad_func == '0));

    // R2
    func_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        func_wr |=> (pad_func == $past(wdata[FUNC_BITS-1:0])));

    // R3
    oe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe == oe_expect);

    // R3
    out_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R4
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |=> (rdata == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind gpio_padbank gpio_padbank_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd),
    .pad_func (pad_func)
);

// File: tb/sim_gpio_padbank.sv
`timescale 1ns/1ps
module sim_gpio_padbank;

    localparam int unsigned NP = 8;
    localparam logic [5:0] A_FUNC = 6'h00;
    localparam logic [5:0] A_DATA = 6'h04;
    localparam logic [5:0] A_PULL = 6'h08;
    localparam logic [5:0] A_DRV  = 6'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pad_pu, pad_pd, pad_slew;
    logic [15:0] pad_drv;
    logic [31:0] pad_func;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_padbank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_drv(pad_drv),
        .pad_slew(pad_slew), .pad_func(pad_func)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [7:0] onebit(input int p, input bit v);
        return v ? (8'h01 << p) : 8'h00;
    endfunction

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_FUNC, r); chk("R1 func", r, 0);
        rd(A_DATA, r); chk("R1 data", r, 0);
        rd(A_PULL, r); chk("R1 pull", r, 0);
        rd(A_DRV,  r); chk("R1 drive", r, 0);
        chk("R1 oe", pad_oe, 0);
        chk("R1 out", pad_out, 0);
        chk("R1 pu", pad_pu, 0);
        chk("R1 pd", pad_pd, 0);

        // R2 / R3: every function code on every pin
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 16; c++) begin
                logic [31:0] v;
                v = 32'(c) << (4 * p);
                wr(A_FUNC, v);
                chk("R2 pad_func", pad_func, v);
                chk("R3 pad_oe", pad_oe, onebit(p, c == 1));
                rd(A_FUNC, r);
                chk("R2 readback", r, v);
            end
        end

        // R3 / R6: all output data patterns, all pins output
        wr(A_FUNC, 32'h1111_1111);
        for (int d = 0; d < 256; d++) begin
            pad_in = ~8'(d);
            wr(A_DATA, 32'(d));
            chk("R3 pad_out", pad_out, 32'(d));
            chk("R3 pad_oe all", pad_oe, 32'hFF);
            rd(A_DATA, r);
            chk("R6 output readback", r, 32'(d));
        end

        // R9: upper data bits not stored
        wr(A_DATA, 32'hFFFF_FF00);
        chk("R9 pad_out", pad_out, 0);
        rd(A_DATA, r);
        chk("R9 readback", r, 0);

        // R6: mixed pins; pins 0,2,4,6 output, 1,3,5 input, 7 alternate fn 2
        wr(A_FUNC, 32'h2101_0101);
        wr(A_DATA, 32'h0000_00F0);
        chk("R3 mixed pad_out", pad_out, 32'h50);
        foreach (pad_in[i]) ;
        for (int k = 0; k < 5; k++) begin
            logic [7:0] iv;
            iv = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hAA : (k == 3) ? 8'h5A : 8'h3C;
            @(negedge clk);
            pad_in = iv;
            settle();
            rd(A_DATA, r);
            chk("R6 mixed read", r, 32'((8'hF0 & 8'h55) | (iv & 8'hAA)));
        end

        // R7: synchroniser latency, all pins input
        wr(A_FUNC, 32'h0);
        @(negedge clk); pad_in = 8'h00;
        settle();
        @(negedge clk); pad_in = 8'hC3;
        @(negedge clk); rd_en = 1'b1; addr = A_DATA;
        @(negedge clk); chk("R7 second edge old", rdata, 32'h00);
        @(negedge clk); chk("R7 third edge new", rdata, 32'hC3);
        rd_en = 1'b0;

        // R4: pull codes on every pin
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 4; c++) begin
                logic [31:0] v;
                v = 32'(c) << (2 * p);
                wr(A_PULL, v | 32'hFFFF_0000);
                chk("R4 pu", pad_pu, onebit(p, c == 3));
                chk("R4 pd", pad_pd, onebit(p, c == 1));
                rd(A_PULL, r);
                chk("R4 readback", r, v);
            end
        end

        // R5: drive codes and slew on every pin
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < 4; c++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [31:0] v;
                    v = (32'(c) << (2 * p)) | (32'(s) << (16 + p));
                    wr(A_DRV, v | 32'hFF00_0000);
                    chk("R5 pad_drv", pad_drv, 32'(c) << (2 * p));
                    chk("R5 pad_slew", pad_slew, onebit(p, s == 1));
                    rd(A_DRV, r);
                    chk("R5 readback", r, v);
                end
            end
        end

        // R8: unmapped and misaligned offsets
        wr(A_FUNC, 32'h1111_1111);
        wr(A_DATA, 32'h0000_00A5);
        wr(A_PULL, 32'h0000_1B1B);
        wr(A_DRV,  32'h00AB_1234);
        for (int w = 4; w < 16; w++) begin
            wr(6'(w * 4), 32'hFFFF_FFFF);
            rd(6'(w * 4), r);
            chk("R8 unmapped read", r, 0);
        end
        wr(6'h05, 32'h0);
        rd(6'h05, r);
        chk("R8 misaligned read", r, 0);
        rd(A_FUNC, r); chk("R8 func kept", r, 32'h1111_1111);
        rd(A_DATA, r); chk("R8 data kept", r, 32'hA5);
        rd(A_PULL, r); chk("R8 pull kept", r, 32'h1B1B);
        rd(A_DRV,  r); chk("R8 drive kept", r, 32'h00AB_1234);

        // R10: rdata holds while rd_en is low
        rd(A_PULL, r);
        @(negedge clk); addr = A_FUNC;
        @(negedge clk); addr = A_DRV;
        @(negedge clk);
        chk("R10 hold", rdata, 32'h1B1B);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule